// File: doc/BRIEF.md
# Chainable Framed Serial Switch Register

This block receives an eight-bit switch pattern over a three-wire serial link and holds it on eight enable outputs. An active-low frame input opens a transfer. While the frame is open, each falling edge of the serial clock shifts one data bit into an internal register, most significant bit first. When the frame closes, the register is copied into an output latch in a single step. The enables therefore never show a pattern that is only partly shifted in.

The bit that will leave the register at the next falling edge is driven on a serial output at every rising edge. Several copies can share one clock and one frame line, with each data input wired to the previous copy's serial output. In that arrangement one long frame loads every copy, and all of them update on the same frame close. All three serial inputs are asynchronous to the block clock. Each passes through a synchronizer, and the serial clock is then edge-detected. Each serial level must therefore stay steady for at least three block clock cycles.

A small controller sequences the work. ST_IDLE waits while the frame is high. The transition IDLE-to-SHIFT is taken when the synchronized frame goes low. ST_SHIFT lasts while the frame stays low. The transition SHIFT-to-COMMIT is taken when the frame returns high. ST_COMMIT lasts one cycle and copies the register into the latch. The transition COMMIT-to-IDLE is then always taken.

Top module: `fsl_chain_latch`

## Requirements
- R1: While rst_n is low, the shift register, the enable latch (sw_en) and sdo are all 0, and they stay 0 until the first frame after release.
- R2: Bits enter most significant bit first. After an eight-bit frame, the first bit sent is on sw_en[7] and the last bit sent is on sw_en[0]; sw_en[i] drives switch i.
- R3: Serial clock edges that arrive while frame_n_in is high are ignored. Neither the shift register nor sw_en changes, and a later frame with no clock edges shows the register unchanged.
- R4: Data is taken only on falling edges of sclk_in. A rising edge with no following falling edge inside the frame shifts nothing.
- R5: sw_en holds its value for the whole of an open frame and changes only in the commit step.
- R6: On every rising sclk_in edge inside a frame, sdo takes the register's MSB. With a second block's sdi wired to sdo, a shared 16-bit frame leaves the first 8 bits in the second block and the last 8 bits in the first block.
- R7: A frame of more than eight bits leaves the last eight bits received. A frame of k < 8 bits shifts the earlier contents up by k places, with the new bits in the low k positions.
- R8: The controller follows IDLE-to-SHIFT, SHIFT-to-COMMIT and COMMIT-to-IDLE as described above. In ST_COMMIT the latch copies the register, so sw_en updates by the fourth clk edge after frame_n_in rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_in | input | 1 | Serial clock, asynchronous |
| frame_n_in | input | 1 | Transfer frame, active low, asynchronous |
| sdi | input | 1 | Serial data in, sampled on sclk_in falling edges |
| sdo | output | 1 | Serial data out toward the next device in the chain |
| sw_en | output | WIDTH | Latched switch enables |

## Verification
The hardest case to reach from the ports is a second device's register. It loads only through the first device's serial output, and that output is one synchronizer and one register stage behind the shared clock. The bench chains two instances and runs frames of 1, 5, 8, 12 and 16 bits. A bench model that moves bits through a 16-bit chain predicts both latches. Frames that close with the serial clock still high, and clock edges sent while no frame is open, are each followed by an empty frame. That empty frame exposes the register through the latch, so the bench can confirm that nothing shifted.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } fsl_state_e;

endpackage

// File: rtl/fsl_sync.sv
// Multi-stage level synchronizer, one flop chain per input signal.
module fsl_sync #(
    parameter int                N_SIG   = 3,
    parameter int                STAGES  = 2,
    parameter logic [N_SIG-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] raw,
    output logic [N_SIG-1:0] lvl
);
    localparam int LAST = STAGES - 1;

    generate
        for (genvar g = 0; g < N_SIG; g++) begin : g_sig
            logic [STAGES-1:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe <= {STAGES{RST_VAL[g]}};
                end else begin
                    pipe <= {pipe[STAGES-2:0], raw[g]};
                end
            end
            assign lvl[g] = pipe[LAST];
        end
    endgenerate

endmodule

// File: rtl/fsl_edge.sv
// Edge detector on an already synchronized level.
module fsl_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= RST_VAL;
        end else begin
            prev <= lvl;
        end
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

endmodule

// File: rtl/fsl_shreg.sv
// Serial-in register; the MSB is presented on sout at each present strobe.
module fsl_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             present_en,
    input  logic             sin,
    output logic [WIDTH-1:0] data,
    output logic             sout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (shift_en) begin
            data <= {data[WIDTH-2:0], sin};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sout <= 1'b0;
        end else if (present_en) begin
            sout <= data[WIDTH-1];
        end
    end

endmodule

// File: rtl/fsl_ctrl.sv
// Frame controller: sequences idle, shifting and the one-cycle commit.
module fsl_ctrl
    import fsl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_idle,
    input  logic [WIDTH-1:0] shreg,
    output fsl_state_e       state,
    output logic [WIDTH-1:0] latch
);
    fsl_state_e state_q;
    fsl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = frame_idle ? ST_IDLE : ST_SHIFT;
            ST_SHIFT:  state_d = frame_idle ? ST_COMMIT : ST_SHIFT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch <= '0;
        end else if (state_q == ST_COMMIT) begin
            latch <= shreg;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/fsl_chain_latch.sv
module fsl_chain_latch
    import fsl_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             frame_n_in,
    input  logic             sdi,
    output logic             sdo,
    output logic [WIDTH-1:0] sw_en
);
    localparam int IDX_SCLK  = 0;
    localparam int IDX_FRAME = 1;
    localparam int IDX_DATA  = 2;
    localparam int N_IN      = 3;
    localparam logic [N_IN-1:0] IN_RST = 3'b010;

    logic [N_IN-1:0]  raw_in;
    logic [N_IN-1:0]  lvl;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             frame_idle;
    logic             shift_en;
    logic             present_en;
    logic [WIDTH-1:0] shreg;
    fsl_state_e       state;

    assign raw_in = {sdi, frame_n_in, sclk_in};

    fsl_sync #(
        .N_SIG  (N_IN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_in),
        .lvl  (lvl)
    );

    fsl_edge #(
        .RST_VAL(1'b0)
    ) u_sclk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl[IDX_SCLK]),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    assign frame_idle = lvl[IDX_FRAME];
    assign shift_en   = sclk_fall & ~frame_idle;
    assign present_en = sclk_rise & ~frame_idle;

    fsl_shreg #(
        .WIDTH(WIDTH)
    ) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .present_en(present_en),
        .sin       (lvl[IDX_DATA]),
        .data      (shreg),
        .sout      (sdo)
    );

    fsl_ctrl #(
        .WIDTH(WIDTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_idle(frame_idle),
        .shreg     (shreg),
        .state     (state),
        .latch     (sw_en)
    );

endmodule

// File: rtl/fsl_chain_latch_chk.sv
module fsl_chain_latch_chk
    import fsl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_idle,
    input logic             sclk_rise,
    input logic             shift_en,
    input fsl_state_e       state,
    input logic [WIDTH-1:0] shreg,
    input logic [WIDTH-1:0] sw_en,
    input logic             sdo
);
    assert_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sw_en == '0 && shreg == '0 && sdo == 1'b0));

    assert_no_shift_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idle |=> $stable(shreg));

    assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (shreg[WIDTH-1:1] == $past(shreg[WIDTH-2:0])));

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COMMIT) |=> $stable(sw_en));

    assert_sdo_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(sdo));

    assert_commit_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (sw_en == $past(shreg)));

    assert_commit_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (state == ST_IDLE));

endmodule

bind fsl_chain_latch fsl_chain_latch_chk #(
    .WIDTH(WIDTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_idle(frame_idle),
    .sclk_rise (sclk_rise),
    .shift_en  (shift_en),
    .state     (state),
    .shreg     (shreg),
    .sw_en     (sw_en),
    .sdo       (sdo)
);

// File: tb/sim_fsl_chain_latch.sv
module sim_fsl_chain_latch;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic frame_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo0, sdo1;
    logic [7:0] sw0, sw1;

    always #2 clk = ~clk;

    fsl_chain_latch u0 (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .frame_n_in(frame_n),
        .sdi(sdi), .sdo(sdo0), .sw_en(sw0)
    );

    fsl_chain_latch u1 (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .frame_n_in(frame_n),
        .sdi(sdo0), .sdo(sdo1), .sw_en(sw1)
    );

    // {bit count, bits left-aligned, first bit sent in bit 15}
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {5'd8,  16'hA500},
        {5'd16, 16'h3CC3},
        {5'd8,  16'hFF00},
        {5'd12, 16'h1230},
        {5'd5,  16'hA800},
        {5'd16, 16'h8001},
        {5'd1,  16'h8000},
        {5'd8,  16'h0000}
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [15:0] chain = '0;   // {second device, first device} model

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic clock_bit(input logic b);
        sdi = b;
        wait_cyc(6);
        sclk = 1'b1;
        wait_cyc(6);
        sclk = 1'b0;
        wait_cyc(6);
        chain = {chain[14:0], b};
    endtask

    task automatic run_frame(input int nb, input logic [15:0] bits);
        logic [7:0] old0;
        old0 = sw0;
        frame_n = 1'b0;
        wait_cyc(6);
        for (int i = 0; i < nb; i++) begin
            clock_bit(bits[15-i]);
        end
        check("R5 latch held during frame", sw0, old0);
        frame_n = 1'b1;
        wait_cyc(12);
    endtask

    initial begin
        wait_cyc(5);
        check("R1 reset sw_en first", sw0, 8'h00);
        check("R1 reset sw_en second", sw1, 8'h00);
        check("R1 reset sdo", {6'd0, sdo1, sdo0}, 8'h00);
        rst_n = 1'b1;
        wait_cyc(4);

        for (int v = 0; v < NV; v++) begin
            run_frame(int'(VEC[v][20:16]), VEC[v][15:0]);
            check("R2/R7/R8 first device", sw0, chain[7:0]);
            check("R6/R7/R8 second device", sw1, chain[15:8]);
        end

        // R3: clock edges with the frame closed must be ignored
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1;
            wait_cyc(6);
            sclk = 1'b1;
            wait_cyc(6);
            sclk = 1'b0;
            wait_cyc(6);
        end
        check("R3 idle edges, first latch", sw0, chain[7:0]);
        run_frame(0, 16'h0000);
        check("R3 empty frame exposes first reg", sw0, chain[7:0]);
        check("R3 empty frame exposes second reg", sw1, chain[15:8]);

        // R4: frame closes after a rising edge; the falling edge lands outside
        frame_n = 1'b0;
        sdi = 1'b1;
        wait_cyc(6);
        sclk = 1'b1;
        wait_cyc(6);
        frame_n = 1'b1;
        wait_cyc(6);
        sclk = 1'b0;
        wait_cyc(12);
        check("R4 rise only, first", sw0, chain[7:0]);
        check("R4 rise only, second", sw1, chain[15:8]);

        // R1: reset after activity clears everything
        rst_n = 1'b0;
        wait_cyc(3);
        check("R1 mid reset sw_en", sw0, 8'h00);
        check("R1 mid reset sdo", {7'd0, sdo0}, 8'h00);
        rst_n = 1'b1;
        chain = '0;
        wait_cyc(4);
        run_frame(0, 16'h0000);
        check("R1 register cleared, first", sw0, 8'h00);
        check("R1 register cleared, second", sw1, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule